// File: doc/BRIEF.md
# Conditioned-Input Arithmetic/Logic Unit

This block is the arithmetic and logic stage of an 8-bit accumulator datapath. It has one adder and three bitwise gates. In front of them sit three small pre-conditioners: one for operand A, one for operand B and one for the carry input. Each conditioner can pass its input, invert it, force it to all zeros or force it to all ones. By choosing these modes, the instruction decoder gets subtract, negate, increment, decrement, clear and set from the same four-function core, without any extra arithmetic hardware.

The 8-bit result is purely combinational. Five status flags are computed alongside it: negative, zero, carry, overflow and digit carry. Each flag is stored in its own register bit on the rising clock edge, but only when that bit's write enable is high. An instruction can therefore change some flags and leave the others as they were.

Top module: `cond_alu8`

## Requirements
- R1: `func_sel` selects the core operation on the conditioned operands: 0 = AND, 1 = OR, 2 = XOR, 3 = ADD (A + B + carry). `result` shows the outcome combinationally.
- R2: `a_mode` and `b_mode` condition their operand before the core: 0 = pass, 1 = bitwise invert, 2 = all zeros, 3 = all ones.
- R3: `c_mode` conditions `carry_in` with the same four codes. The conditioned carry affects only ADD.
- R4: The negative flag is bit 0 of `flags`. It takes bit 7 of the result.
- R5: The zero flag is bit 1 of `flags`. It is set when all eight result bits are 0.
- R6: The carry flag is bit 2 of `flags`. It takes the carry out of bit 7 for ADD and is 0 for AND, OR and XOR.
- R7: The overflow flag is bit 3 of `flags`. It is the XOR of the carries out of bits 7 and 6 for ADD, and 0 for the logic functions.
- R8: The digit-carry flag is bit 4 of `flags`. It is the carry out of bit 3 into bit 4 for ADD, and 0 for the logic functions.
- R9: A flag bit is loaded on a rising clock edge only when the matching bit of `flag_wen` is 1. Otherwise it keeps its value.
- R10: While `rst` is high at a rising edge, all flag bits are cleared to 0.
- R11: The derived operations give the expected two's-complement results:
  - SUB (B invert, carry one) gives A − B.
  - NEG (A zeros, B invert, carry one) gives −B.
  - INC (B zeros, carry one) gives A + 1.
  - DEC (B ones, carry zero) gives A − 1.
  - CLR (AND with B zeros) gives 0.
  - SET (OR with B ones) gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register loads on the rising edge |
| rst | input | 1 | Active-high synchronous reset for the flags |
| op_a | input | 8 | Operand A |
| op_b | input | 8 | Operand B |
| carry_in | input | 1 | Raw carry input |
| func_sel | input | 2 | Core function code |
| a_mode | input | 2 | Conditioner mode for operand A |
| b_mode | input | 2 | Conditioner mode for operand B |
| c_mode | input | 2 | Conditioner mode for the carry input |
| flag_wen | input | 5 | Per-flag write enables, in the same bit order as `flags` |
| result | output | 8 | Combinational result |
| flags | output | 5 | Registered flags: {digit carry, overflow, carry, zero, negative} |

## Verification
The hardest cases to reach from the ports are those where overflow and digit carry disagree with the carry flag. Examples are a carry out of bit 3 with no carry out of bit 7, and a signed overflow with no unsigned carry. The stimulus sets these up on purpose with operand pairs such as 0x7F + 0x01 and 0x08 + 0x08, and it includes one case driven only through the carry conditioner. A second hard case is a partial write-enable mask issued right after a logic operation: carry must be cleared only where it is enabled. The bench checks this by changing all flags first and then writing a single bit.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [1:0] {
        FN_AND = 2'd0,
        FN_OR  = 2'd1,
        FN_XOR = 2'd2,
        FN_ADD = 2'd3
    } alu_fn_e;

    typedef enum logic [1:0] {
        CM_PASS = 2'd0,
        CM_INV  = 2'd1,
        CM_ZERO = 2'd2,
        CM_ONE  = 2'd3
    } cond_mode_e;

    localparam int NFLAGS = 5;

    // Bit 0 (neg) is the LSB of the packed vector.
    typedef struct packed {
        logic dc;
        logic ovf;
        logic cy;
        logic zero;
        logic neg;
    } flags_t;

endpackage

// File: rtl/alu8_cond.sv
module alu8_cond
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    always_comb begin
        unique case (cond_mode_e'(mode))
            CM_PASS: dout = din;
            CM_INV:  dout = ~din;
            CM_ZERO: dout = '0;
            default: dout = '1;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic [1:0]   fn,
    output logic [W-1:0] res,
    output flags_t       fl
);

    localparam int HALF = W / 2;

    logic [W:0]   chain;
    logic [W-1:0] sum;

    assign chain[0] = cin;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]     = a[i] ^ b[i] ^ chain[i];
            assign chain[i+1] = (a[i] & b[i]) | ((a[i] ^ b[i]) & chain[i]);
        end
    endgenerate

    always_comb begin
        fl = '0;
        unique case (alu_fn_e'(fn))
            FN_AND:  res = a & b;
            FN_OR:   res = a | b;
            FN_XOR:  res = a ^ b;
            default: begin
                res    = sum;
                fl.cy  = chain[W];
                fl.ovf = chain[W] ^ chain[W-1];
                fl.dc  = chain[HALF];
            end
        endcase
        fl.neg  = res[W-1];
        fl.zero = (res == '0);
    end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  flags_t            new_fl,
    input  logic [NFLAGS-1:0] wen,
    output flags_t            fl_q
);

    typedef struct packed {
        flags_t fl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NFLAGS; i++) begin
            if (wen[i]) st_d.fl[i] = new_fl[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fl_q = st_q.fl;

    generate
        for (genvar k = 0; k < NFLAGS; k++) begin : g_chk
            assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
                !wen[k] |=> $stable(fl_q[k]));
            assert_load_R9: assert property (@(posedge clk) disable iff (rst)
                wen[k] |=> fl_q[k] == $past(new_fl[k]));
        end
    endgenerate

    assert_reset_R10: assert property (@(posedge clk) rst |=> fl_q == '0);

endmodule

// File: rtl/cond_alu8.sv
module cond_alu8
    import alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] op_a,
    input  logic [7:0] op_b,
    input  logic       carry_in,
    input  logic [1:0] func_sel,
    input  logic [1:0] a_mode,
    input  logic [1:0] b_mode,
    input  logic [1:0] c_mode,
    input  logic [4:0] flag_wen,
    output logic [7:0] result,
    output logic [4:0] flags
);

    localparam int W = 8;

    logic [W-1:0] a_c, b_c;
    logic [0:0]   c_c;
    flags_t       fl_d, fl_q;

    alu8_cond #(.W(W)) u_cond_a (.mode(a_mode), .din(op_a), .dout(a_c));
    alu8_cond #(.W(W)) u_cond_b (.mode(b_mode), .din(op_b), .dout(b_c));
    alu8_cond #(.W(1)) u_cond_c (.mode(c_mode), .din(carry_in), .dout(c_c));

    alu8_core #(.W(W)) u_core (
        .a(a_c), .b(b_c), .cin(c_c[0]), .fn(func_sel),
        .res(result), .fl(fl_d)
    );

    alu8_flags u_flags (
        .clk(clk), .rst(rst), .new_fl(fl_d), .wen(flag_wen), .fl_q(fl_q)
    );

    assign flags = fl_q;

    assert_neg_R4: assert property (@(posedge clk) disable iff (rst)
        flag_wen[0] |=> flags[0] == $past(result[W-1]));
    assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
        flag_wen[1] |=> flags[1] == ($past(result) == '0));
    assert_logic_no_carry_R6: assert property (@(posedge clk) disable iff (rst)
        (func_sel != FN_ADD && flag_wen[2]) |=> !flags[2]);
    assert_logic_no_ovf_R7: assert property (@(posedge clk) disable iff (rst)
        (func_sel != FN_ADD && flag_wen[3]) |=> !flags[3]);
    assert_set_R11: assert property (@(posedge clk) disable iff (rst)
        (func_sel == FN_OR && b_mode == CM_ONE) |-> result == 8'hFF);
    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (func_sel == FN_AND && b_mode == CM_ZERO) |-> result == 8'h00);

endmodule

// File: tb/cond_alu8_bench.sv
module cond_alu8_bench;

    logic       clk = 0;
    logic       rst = 1;
    logic [7:0] op_a = 0, op_b = 0;
    logic       carry_in = 0;
    logic [1:0] func_sel = 0, a_mode = 0, b_mode = 0, c_mode = 0;
    logic [4:0] flag_wen = 0;
    logic [7:0] result;
    logic [4:0] flags;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [4:0] exp_fl = 0;

    always #5 clk = ~clk;

    cond_alu8 u_cond_alu8 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] cnd(input logic [1:0] m, input logic [7:0] v);
        case (m)
            2'd0: return v;
            2'd1: return ~v;
            2'd2: return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

    // returns {flags[4:0], result[7:0]}
    function automatic logic [12:0] model(input logic [7:0] a, b, input logic c,
                                          input logic [1:0] f, am, bm, cm);
        logic [7:0] ca, cb, r;
        logic cc, cy, ov, dc, c6;
        int s;
        ca = cnd(am, a); cb = cnd(bm, b); cc = cnd(cm, {7'b0, c}) & 1'b1;
        cy = 0; ov = 0; dc = 0;
        case (f)
            2'd0: r = ca & cb;
            2'd1: r = ca | cb;
            2'd2: r = ca ^ cb;
            default: begin
                s  = int'(ca) + int'(cb) + int'(cc);
                r  = s[7:0];
                cy = s[8];
                c6 = ((int'(ca[6:0]) + int'(cb[6:0]) + int'(cc)) >> 7) & 1;
                ov = cy ^ c6;
                dc = ((int'(ca[3:0]) + int'(cb[3:0]) + int'(cc)) >> 4) & 1;
            end
        endcase
        return {dc, ov, cy, (r == 0), r[7], r};
    endfunction

    task automatic apply(input logic [7:0] a, b, input logic c, input logic [1:0] f,
                         am, bm, cm, input logic [4:0] wen, input string req);
        logic [12:0] m;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = c; func_sel = f;
        a_mode = am; b_mode = bm; c_mode = cm; flag_wen = wen;
        m = model(a, b, c, f, am, bm, cm);
        #1 chk(result === m[7:0], {req, " result"}, result, m[7:0]);
        for (int i = 0; i < 5; i++) if (wen[i]) exp_fl[i] = m[8+i];
        @(posedge clk);
        #1 chk(flags === exp_fl, {req, " flags"}, flags, exp_fl);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1; flag_wen = 0;
        @(posedge clk); #1;
        exp_fl = 0;
        chk(flags === 5'b0, "R10 reset clears flags", flags, 0);
        @(negedge clk); rst = 0;
    endtask

    task automatic t_logic();
        apply(8'hF0, 8'h3C, 0, 2'd0, 0, 0, 0, 5'h1F, "R1 AND R6 R7 R8");
        apply(8'hF0, 8'h0C, 0, 2'd1, 0, 0, 0, 5'h1F, "R1 OR R4");
        apply(8'hA5, 8'hA5, 1, 2'd2, 0, 0, 0, 5'h1F, "R1 XOR R5");
        apply(8'hFF, 8'h01, 1, 2'd3, 0, 0, 0, 5'h1F, "R1 ADD R6");
    endtask

    task automatic t_modes();
        apply(8'h35, 8'h00, 0, 2'd1, 2'd1, 2'd0, 0, 5'h1F, "R2 invert A");
        apply(8'h35, 8'h77, 0, 2'd2, 2'd0, 2'd3, 0, 5'h1F, "R2 ones B");
        apply(8'h10, 8'h20, 0, 2'd3, 0, 0, 2'd3, 5'h1F, "R3 carry forced one");
        apply(8'h10, 8'h20, 1, 2'd3, 0, 0, 2'd1, 5'h1F, "R3 carry inverted");
        apply(8'h10, 8'h20, 1, 2'd0, 0, 0, 2'd3, 5'h1F, "R3 carry ignored on AND");
    endtask

    task automatic t_corner();
        apply(8'h7F, 8'h01, 0, 2'd3, 0, 0, 0, 5'h1F, "R7 signed overflow no carry");
        apply(8'h80, 8'h80, 0, 2'd3, 0, 0, 0, 5'h1F, "R7 R6 overflow with carry");
        apply(8'h08, 8'h08, 0, 2'd3, 0, 0, 0, 5'h1F, "R8 digit carry only");
        apply(8'h0F, 8'h00, 1, 2'd3, 0, 2'd2, 2'd0, 5'h1F, "R8 digit carry via carry-in");
    endtask

    task automatic t_derived();
        apply(8'h50, 8'h30, 0, 2'd3, 0, 2'd1, 2'd3, 5'h1F, "R11 SUB");
        apply(8'h30, 8'h50, 0, 2'd3, 0, 2'd1, 2'd3, 5'h1F, "R11 SUB borrow");
        apply(8'h00, 8'h05, 0, 2'd3, 2'd2, 2'd1, 2'd3, 5'h1F, "R11 NEG");
        apply(8'hFF, 8'h00, 0, 2'd3, 0, 2'd2, 2'd3, 5'h1F, "R11 INC wrap");
        apply(8'h00, 8'h00, 1, 2'd3, 0, 2'd3, 2'd2, 5'h1F, "R11 DEC wrap");
        apply(8'h9A, 8'h12, 0, 2'd0, 0, 2'd2, 0, 5'h1F, "R11 CLR");
        apply(8'h9A, 8'h12, 0, 2'd1, 0, 2'd3, 0, 5'h1F, "R11 SET");
    endtask

    task automatic t_mask();
        apply(8'hFF, 8'h81, 0, 2'd3, 0, 0, 0, 5'h1F, "R9 set all");
        apply(8'h00, 8'h00, 0, 2'd0, 0, 0, 0, 5'h04, "R9 only carry written");
        apply(8'h00, 8'h00, 0, 2'd0, 0, 0, 0, 5'h00, "R9 no write holds");
        apply(8'h7F, 8'h01, 0, 2'd3, 0, 0, 0, 5'h09, "R9 neg and ovf written");
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 60; i++) begin
            apply($urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
                  $urandom, $urandom, "R1 R2 R3 R9 sweep");
        end
    endtask

    initial begin
        void'($urandom(32'h1234));
        repeat (2) @(posedge clk);
        t_reset();
        t_logic();
        t_modes();
        t_corner();
        t_derived();
        t_mask();
        t_sweep();
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule